// File: doc/BRIEF.md
# Discontinuous-Mode Boost Switch Cycle Sequencer

This block is the clocked core of a boost power-factor stage that runs in discontinuous conduction. It commands the switch gate through repeated on/off cycles. It turns the switch on only when the inductor current is back at zero, the forced off interval has run out, the synchronization arbiter permits it, and the protections allow it. It turns the switch off when the timing ramp crosses the control level or when the current limit trips.

A single sense flag carries two meanings. While the gate is high, the flag means overcurrent. While the gate is low, it means the inductor still carries current. The flag is masked for a fixed number of cycles after every turn-on, so that switching spikes are not taken as an overcurrent. The ramp generator and all comparators sit outside the block and reach it as digital flags. The block returns a ramp-reset request that holds the ramp at zero whenever the gate is off.

Top module: `dcm_switch_seq`

## Requirements
- R1: While rst_ni is low and right after it rises, state_o is 0, gate_o is 0 and ramp_rst_o is 1.
- R2: state_o encodes the sequence as 0 = idle, 1 = on with blanking, 2 = on, 3 = forced off-wait. gate_o is high only in states 1 and 2 while prot_en_i is high. ramp_rst_o is 1 exactly in states 0 and 3, so gate_o and ramp_rst_o are never both high.
- R3: In idle, if prot_en_i=1, sense_lo_i=0 and sync_ok_i=1 are all sampled at a clock edge, the state becomes 1 and gate_o goes high after that edge. If prot_en_i or sync_ok_i is low, the block stays in idle.
- R4: In idle, sense_lo_i=1 (zero current not yet reached) blocks turn-on for as long as it is high. The first edge that samples it low, with the other conditions met, starts the on-time.
- R5: State 1 lasts exactly BLANK_CYC cycles and is then followed by state 2. sense_lo_i has no effect during state 1.
- R6: In state 2, sense_lo_i=1 at an edge ends the on-time: the next state is 3 and gate_o is low. Without it, and with ramp_hi_i=0, the gate stays on.
- R7: ramp_hi_i=1 at an edge in state 1 or 2 moves the block to state 3. ramp_hi_i does not block turn-on, so if it is still high at turn-on, the gate is high for exactly one cycle.
- R8: State 3 lasts exactly MIN_OFF_CYC cycles whatever the inputs, and then becomes idle. No turn-on happens before that.
- R9: prot_en_i low forces gate_o low in the same cycle. If the gate was on, the next state is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ramp_hi_i | input | 1 | Ramp has crossed the control level |
| sense_lo_i | input | 1 | Current sense below threshold (overcurrent when on, current not yet zero when off) |
| sync_ok_i | input | 1 | Turn-on permit from the synchronization arbiter |
| prot_en_i | input | 1 | Global enable from the protections |
| gate_o | output | 1 | Switch gate command |
| ramp_rst_o | output | 1 | Hold the ramp at zero |
| state_o | output | 2 | Sequence state (0 idle, 1 blank, 2 on, 3 off-wait) |

## Verification
Every flag sampled at a clock edge changes state_o, gate_o and ramp_rst_o one cycle later. The one exception is a drop of prot_en_i, which clears gate_o within the same cycle. The blanking phase spans exactly BLANK_CYC cycles after turn-on, and the off-wait phase spans exactly MIN_OFF_CYC cycles after turn-off. The bench drives inputs on falling edges and reads outputs on the next falling edge. It counts the falling edges from the one where a phase was first seen, so each expected value is read in the single cycle it is due. The same-cycle gate drop is read one time step after prot_en_i is lowered and before any rising edge.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_ON    = 2'd2,
    ST_OFF   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dcm_span_timer.sv
module dcm_span_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned W = (LEN < 2) ? 1 : $clog2(LEN);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  generate
    if (LEN <= 1) begin : g_single
      assign done_o = run_i;
    end else begin : g_count
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               cnt_q <= '0;
        else if (!run_i)           cnt_q <= '0;
        else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
      end
      assign done_o = run_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/dcm_on_qual.sv
module dcm_on_qual (
  input  logic prot_en_i,
  input  logic sense_lo_i,
  input  logic sync_ok_i,
  output logic turn_ok_o
);
  // sense low while off means current still flowing
  assign turn_ok_o = prot_en_i && !sense_lo_i && sync_ok_i;
endmodule

// File: rtl/dcm_seq_fsm.sv
module dcm_seq_fsm
  import dcm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ramp_hi_i,
  input  logic       sense_lo_i,
  input  logic       prot_en_i,
  input  logic       turn_ok_i,
  input  logic       blank_done_i,
  input  logic       off_done_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (turn_ok_i) state_d = ST_BLANK;
      ST_BLANK: begin
        if (!prot_en_i || ramp_hi_i) state_d = ST_OFF;
        else if (blank_done_i)       state_d = ST_ON;
      end
      ST_ON:    if (!prot_en_i || ramp_hi_i || sense_lo_i) state_d = ST_OFF;
      ST_OFF:   if (off_done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dcm_switch_seq.sv
module dcm_switch_seq
  import dcm_pkg::*;
#(
  parameter int unsigned BLANK_CYC   = 40,
  parameter int unsigned MIN_OFF_CYC = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ramp_hi_i,
  input  logic       sense_lo_i,
  input  logic       sync_ok_i,
  input  logic       prot_en_i,
  output logic       gate_o,
  output logic       ramp_rst_o,
  output logic [1:0] state_o
);
  seq_state_e state;
  logic turn_ok, blank_done, off_done, in_blank, in_off, on_phase;

  dcm_on_qual u_qual (
    .prot_en_i (prot_en_i),
    .sense_lo_i(sense_lo_i),
    .sync_ok_i (sync_ok_i),
    .turn_ok_o (turn_ok)
  );

  dcm_span_timer #(.LEN(BLANK_CYC)) u_blank_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (in_blank),
    .done_o(blank_done)
  );

  dcm_span_timer #(.LEN(MIN_OFF_CYC)) u_off_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (in_off),
    .done_o(off_done)
  );

  dcm_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ramp_hi_i   (ramp_hi_i),
    .sense_lo_i  (sense_lo_i),
    .prot_en_i   (prot_en_i),
    .turn_ok_i   (turn_ok),
    .blank_done_i(blank_done),
    .off_done_i  (off_done),
    .state_o     (state)
  );

  assign in_blank   = (state == ST_BLANK);
  assign in_off     = (state == ST_OFF);
  assign on_phase   = in_blank || (state == ST_ON);
  // protection drop kills the gate without waiting for an edge
  assign gate_o     = on_phase && prot_en_i;
  assign ramp_rst_o = !on_phase;
  assign state_o    = state;
endmodule

// File: rtl/dcm_switch_seq_chk.sv
module dcm_switch_seq_chk #(
  parameter int unsigned BLANK_CYC   = 40,
  parameter int unsigned MIN_OFF_CYC = 200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ramp_hi_i,
  input logic       sense_lo_i,
  input logic       sync_ok_i,
  input logic       prot_en_i,
  input logic       gate_o,
  input logic       ramp_rst_o,
  input logic [1:0] state_o
);
  localparam int unsigned CW = $clog2(MIN_OFF_CYC + BLANK_CYC + 2);
  logic [CW-1:0] off_cnt, blk_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cnt <= '0;
      blk_cnt <= '0;
    end else begin
      off_cnt <= (state_o == 2'd3) ? off_cnt + 1'b1 : '0;
      blk_cnt <= (state_o == 2'd1) ? blk_cnt + 1'b1 : '0;
    end
  end

  assert_gate_ramp_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o && ramp_rst_o));

  assert_turn_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && prot_en_i && !sense_lo_i && sync_ok_i) |=> (state_o == 2'd1));

  assert_zcd_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && sense_lo_i) |=> (state_o == 2'd0));

  assert_blank_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && prot_en_i && !ramp_hi_i && blk_cnt < CW'(BLANK_CYC - 1))
      |=> (state_o == 2'd1));

  assert_blank_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && prot_en_i && !ramp_hi_i && blk_cnt == CW'(BLANK_CYC - 1))
      |=> (state_o == 2'd2));

  assert_ocp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && sense_lo_i) |=> (state_o == 2'd3 && !gate_o));

  assert_ramp_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 2'd1 || state_o == 2'd2) && ramp_hi_i) |=> (state_o == 2'd3));

  assert_off_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && off_cnt < CW'(MIN_OFF_CYC - 1)) |=> (state_o == 2'd3));

  assert_off_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && off_cnt == CW'(MIN_OFF_CYC - 1)) |=> (state_o == 2'd0));

  assert_prot_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_en_i |-> !gate_o);

  assert_prot_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 2'd1 || state_o == 2'd2) && !prot_en_i) |=> (state_o == 2'd3));
endmodule

bind dcm_switch_seq dcm_switch_seq_chk #(
  .BLANK_CYC  (BLANK_CYC),
  .MIN_OFF_CYC(MIN_OFF_CYC)
) u_chk (.*);

// File: tb/sim_dcm_switch_seq.sv
module sim_dcm_switch_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK      = 40;
  localparam int MIN_OFF    = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ramp_hi = 1'b0, sense_lo = 1'b0, sync_ok = 1'b0, prot_en = 1'b1;
  logic gate, ramp_rst;
  logic [1:0] state;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcm_switch_seq #(.BLANK_CYC(BLANK), .MIN_OFF_CYC(MIN_OFF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ramp_hi_i(ramp_hi), .sense_lo_i(sense_lo),
    .sync_ok_i(sync_ok), .prot_en_i(prot_en), .gate_o(gate),
    .ramp_rst_o(ramp_rst), .state_o(state)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called on the first cycle of off-wait
  task automatic end_off();
    sync_ok = 1'b0;
    tick(MIN_OFF - 1);
    chk("R8 off-wait still held", int'(state), 3);
    chk("R8 gate low in off-wait", int'(gate), 0);
    tick(1);
    chk("R8 idle after min off", int'(state), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset state", int'(state), 0);
    chk("R1 reset gate", int'(gate), 0);
    chk("R1 reset ramp_rst", int'(ramp_rst), 1);
    rst_n = 1'b1;
    tick(2);
    chk("R1 idle after reset", int'(state), 0);
    chk("R1 gate after reset", int'(gate), 0);
  endtask

  task automatic t_blocked();
    sync_ok = 1'b0;
    tick(3);
    chk("R3 no permit stays idle", int'(state), 0);
    sync_ok = 1'b1; sense_lo = 1'b1;
    tick(6);
    chk("R4 zcd blocks turn-on", int'(state), 0);
    chk("R4 gate low while current flows", int'(gate), 0);
    sense_lo = 1'b0; prot_en = 1'b0;
    tick(3);
    chk("R3 prot low stays idle", int'(state), 0);
    prot_en = 1'b1;
    tick(1);
    chk("R4 turn-on after release", int'(state), 1);
    ramp_hi = 1'b1;
    tick(1);
    chk("R7 ramp ends blank phase", int'(state), 3);
    ramp_hi = 1'b0;
    end_off();
  endtask

  task automatic t_blank_ocp();
    sync_ok = 1'b1;
    tick(1);
    chk("R3 turn-on state", int'(state), 1);
    chk("R2 gate high when on", int'(gate), 1);
    chk("R2 ramp_rst low when on", int'(ramp_rst), 0);
    sense_lo = 1'b1; sync_ok = 1'b0;
    tick(BLANK - 1);
    chk("R5 sense ignored in blank", int'(state), 1);
    chk("R5 gate held in blank", int'(gate), 1);
    tick(1);
    chk("R5 blank length", int'(state), 2);
    tick(1);
    chk("R6 ocp ends on-time", int'(state), 3);
    chk("R6 gate low after ocp", int'(gate), 0);
    sense_lo = 1'b0;
    end_off();
  endtask

  task automatic t_on_then_ocp();
    sync_ok = 1'b1;
    tick(1);
    sync_ok = 1'b0;
    tick(BLANK);
    chk("R5 on after blank", int'(state), 2);
    tick(5);
    chk("R6 stays on without sense", int'(state), 2);
    chk("R6 gate on without sense", int'(gate), 1);
    sense_lo = 1'b1;
    tick(1);
    chk("R6 ocp in on state", int'(state), 3);
    chk("R2 ramp_rst high in off-wait", int'(ramp_rst), 1);
    sense_lo = 1'b0;
    end_off();
  endtask

  task automatic t_ramp();
    sync_ok = 1'b1;
    tick(1);
    sync_ok = 1'b0;
    tick(3);
    chk("R7 blank before ramp", int'(state), 1);
    ramp_hi = 1'b1;
    tick(1);
    chk("R7 ramp in blank ends on", int'(state), 3);
    end_off();
    sync_ok = 1'b1;
    tick(1);
    chk("R7 turn-on with ramp high", int'(state), 1);
    chk("R7 gate high one cycle", int'(gate), 1);
    tick(1);
    chk("R7 one-cycle on-time", int'(state), 3);
    ramp_hi = 1'b0;
    end_off();
    sync_ok = 1'b1;
    tick(1);
    sync_ok = 1'b0;
    tick(BLANK + 2);
    chk("R7 on before ramp", int'(state), 2);
    ramp_hi = 1'b1;
    tick(1);
    chk("R7 ramp in on state", int'(state), 3);
    ramp_hi = 1'b0;
    end_off();
  endtask

  task automatic t_prot();
    sync_ok = 1'b1;
    tick(1);
    sync_ok = 1'b0;
    tick(BLANK + 2);
    chk("R9 on before drop", int'(gate), 1);
    prot_en = 1'b0;
    #1;
    chk("R9 gate low same cycle", int'(gate), 0);
    tick(1);
    chk("R9 off-wait after drop", int'(state), 3);
    end_off();
    sync_ok = 1'b1;
    tick(3);
    chk("R3 prot low blocks turn-on", int'(state), 0);
    prot_en = 1'b1; sync_ok = 1'b0;
    tick(1);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_blocked();
    t_blank_ocp();
    t_on_then_ocp();
    t_ramp();
    t_prot();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule